// File: doc/BRIEF.md
# Software Store/Recall Sequence Detector

This block watches an asynchronous SRAM bus after its chip-enable has been brought into the system clock domain. It looks for a fixed run of six back-to-back read accesses whose low fourteen address bits spell out a request for a nonvolatile operation. The last access of the run selects the operation: one key asks for the SRAM contents to be saved to the nonvolatile array (store), the other asks for the saved contents to be loaded back (recall).

A match produces a single-cycle request pulse for the nonvolatile cycle controller. It also raises a level that tells the data path to float its outputs. The level stays up until the controller drops its busy flag. The first five accesses of the run are ordinary reads, and the detector does not interfere with them. A write, an unexpected address or an extra chip-enable strobe in the middle of the run cancels it. Bus activity is ignored while the controller reports busy, and the run starts over once busy is released.

Top module: `nv_seq_detect`

## Requirements
- R1: `bus_ce_ni` passes through a two-flop synchronizer, and each high-to-low transition of the synchronized signal is one access strobe. A request pulse rises at the third rising clock edge after `bus_ce_ni` goes low, and one low pulse never counts as two accesses.
- R2: Only `bus_addr_i[13:0]` is compared. Bit 14 has no effect on any step.
- R3: The first five strobed addresses must be 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F, in that order, each with `bus_we_ni` high.
- R4: A sixth strobed read at 0x0FC0 gives a one-cycle `store_req_o` pulse. A sixth strobed read at 0x0C63 gives a one-cycle `recall_req_o` pulse. The two pulses are never high together.
- R5: A strobed address other than the expected next one cancels the run, and no request follows from it.
- R6: A strobe with `bus_we_ni` low cancels the run at any step, whatever the address.
- R7: A repeated strobe of the same step's address (double clocking) cancels the run. A cancelling strobe at 0x0E38 counts as step 1 of a new run.
- R8: `out_hiz_o` rises together with either request pulse and stays high until the clock edge after `busy_i` falls.
- R9: Strobes seen while `busy_i` is high have no effect. On the edge where `busy_i` falls, the run returns to its start.
- R10: After `rst_ni` is asserted, `store_req_o`, `recall_req_o` and `out_hiz_o` are low and the run is at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_ce_ni | input | 1 | SRAM bus chip-enable, active low, asynchronous |
| bus_we_ni | input | 1 | SRAM bus write-enable, active low |
| bus_addr_i | input | 15 | SRAM bus address |
| busy_i | input | 1 | Nonvolatile cycle in progress, from the controller |
| store_req_o | output | 1 | One-cycle store request |
| recall_req_o | output | 1 | One-cycle recall request |
| out_hiz_o | output | 1 | Data outputs must float |

## Verification
The step counter is internal, so a wrong step shows up at the ports only when the sixth access arrives. Either a request appears that should not, or an expected pulse is missing, three clock edges after that access's chip-enable falls. For this reason the bench checks the request counts and `out_hiz_o` after every single access, against a step model of its own. The directed runs cover cancellation at each step: a complete run after a write, a wrong address, a double clock or a busy window must produce no pulse, and a mismatch there exposes a missed reset of the step. A stuck hold in `out_hiz_o` becomes visible at the first access after busy is released.

// File: rtl/nvsd_pkg.sv
package nvsd_pkg;
  localparam int SEQ_LEN   = 6;
  localparam int PFX_N     = SEQ_LEN - 1;
  localparam int CMP_W     = 14;
  localparam int STEP_W    = $clog2(SEQ_LEN);

  typedef logic [CMP_W-1:0] cmp_addr_t;

  localparam cmp_addr_t STORE_KEY  = 14'h0FC0;
  localparam cmp_addr_t RECALL_KEY = 14'h0C63;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_STORE  = 2'd1,
    REQ_RECALL = 2'd2
  } req_e;

  function automatic cmp_addr_t prefix_addr(input int idx);
    case (idx)
      0:       return 14'h0E38;
      1:       return 14'h31C7;
      2:       return 14'h03E0;
      3:       return 14'h3C1F;
      default: return 14'h303F;
    endcase
  endfunction
endpackage

// File: rtl/nvsd_sync.sv
module nvsd_sync #(
  parameter int   STAGES    = 2,
  parameter int   WIDTH     = 1,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= {WIDTH{RESET_VAL}};
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nvsd_edge.sv
module nvsd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/nvsd_fsm.sv
module nvsd_fsm
  import nvsd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o,
  output logic              out_hiz_o
);
  logic [STEP_W-1:0] step_q, step_d;
  logic [SEQ_LEN-1:0] pfx_hit;
  cmp_addr_t key;
  req_e req_d;
  logic busy_q, busy_release, hiz_q, hiz_d, store_q, recall_q;

  assign key = addr_i[CMP_W-1:0];

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_hit
    if (i < PFX_N) begin : g_pfx
      assign pfx_hit[i] = (key == prefix_addr(i));
    end else begin : g_pad
      assign pfx_hit[i] = 1'b0;
    end
  end

  assign busy_release = busy_q & ~busy_i;

  always_comb begin
    step_d = step_q;
    req_d  = REQ_NONE;
    if (busy_release) begin
      step_d = '0;
    end else if (strobe_i && !busy_i) begin
      if (!we_ni) begin
        step_d = '0;
      end else if (int'(step_q) < PFX_N && pfx_hit[step_q]) begin
        step_d = step_q + 1'b1;
      end else if (int'(step_q) == PFX_N && key == STORE_KEY) begin
        req_d  = REQ_STORE;
        step_d = '0;
      end else if (int'(step_q) == PFX_N && key == RECALL_KEY) begin
        req_d  = REQ_RECALL;
        step_d = '0;
      end else if (pfx_hit[0]) begin
        step_d = STEP_W'(1);
      end else begin
        step_d = '0;
      end
    end
  end

  always_comb begin
    hiz_d = hiz_q;
    if (req_d != REQ_NONE) hiz_d = 1'b1;
    else if (busy_release) hiz_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q   <= '0;
      busy_q   <= 1'b0;
      hiz_q    <= 1'b0;
      store_q  <= 1'b0;
      recall_q <= 1'b0;
    end else begin
      step_q   <= step_d;
      busy_q   <= busy_i;
      hiz_q    <= hiz_d;
      store_q  <= (req_d == REQ_STORE);
      recall_q <= (req_d == REQ_RECALL);
    end
  end

  assign store_req_o  = store_q;
  assign recall_req_o = recall_q;
  assign out_hiz_o    = hiz_q;

  assert_excl_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_req_o && recall_req_o));
  assert_store_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_req_o |=> !store_req_o);
  assert_recall_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |=> !recall_req_o);
  assert_hiz_with_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_req_o || recall_req_o) |-> out_hiz_o);
  assert_quiet_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !(store_req_o || recall_req_o));
  assert_release_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_release |=> (step_q == '0 && !out_hiz_o));
  assert_write_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !we_ni) |=> (step_q == '0 && !store_req_o && !recall_req_o));
endmodule

// File: rtl/nv_seq_detect.sv
module nv_seq_detect #(
  parameter int ADDR_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_ce_ni,
  input  logic              bus_we_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              busy_i,
  output logic              store_req_o,
  output logic              recall_req_o,
  output logic              out_hiz_o
);
  logic ce_sync_n, strobe;

  nvsd_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bus_ce_ni),
    .q_o   (ce_sync_n)
  );

  nvsd_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ce_sync_n),
    .fall_o(strobe)
  );

  nvsd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .we_ni       (bus_we_ni),
    .addr_i      (bus_addr_i),
    .busy_i      (busy_i),
    .store_req_o (store_req_o),
    .recall_req_o(recall_req_o),
    .out_hiz_o   (out_hiz_o)
  );
endmodule

// File: tb/tb_nv_seq_detect.sv
`timescale 1ns/1ps
module tb_nv_seq_detect;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [14:0] addr = '0;
  logic store_o, recall_o, hiz_o;
  int vectors = 0, miscompares = 0;
  int st_cnt = 0, rc_cnt = 0;
  int m_step = 0;
  bit m_hiz = 1'b0, m_busy = 1'b0;

  always #5 clk = ~clk;

  nv_seq_detect dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_ce_ni(ce_n), .bus_we_ni(we_n),
    .bus_addr_i(addr), .busy_i(busy),
    .store_req_o(store_o), .recall_req_o(recall_o), .out_hiz_o(hiz_o)
  );

  always @(negedge clk) begin
    if (store_o) st_cnt++;
    if (recall_o) rc_cnt++;
  end

  function automatic logic [13:0] seq_at(input int i);
    logic [13:0] t [5] = '{14'h0E38, 14'h31C7, 14'h03E0, 14'h3C1F, 14'h303F};
    return t[i];
  endfunction

  // returns 0 none, 1 store, 2 recall; updates m_step
  function automatic int model_step(input logic [14:0] a, input logic wn);
    logic [13:0] k = a[13:0];
    int r = 0;
    if (m_busy) return 0;
    if (!wn) m_step = 0;
    else if (m_step < 5 && k == seq_at(m_step)) m_step++;
    else if (m_step == 5 && k == 14'h0FC0) begin r = 1; m_step = 0; end
    else if (m_step == 5 && k == 14'h0C63) begin r = 2; m_step = 0; end
    else if (k == 14'h0E38) m_step = 1;
    else m_step = 0;
    if (r != 0) m_hiz = 1'b1;
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic access(input logic [14:0] a, input logic wn, input string tag);
    int s0 = st_cnt, r0 = rc_cnt, er;
    er = model_step(a, wn);
    @(negedge clk); addr = a; we_n = wn; ce_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
    check({tag, " store"}, st_cnt - s0, (er == 1) ? 1 : 0);
    check({tag, " recall"}, rc_cnt - r0, (er == 2) ? 1 : 0);
    check({tag, " R8 hiz"}, int'(hiz_o), int'(m_hiz));
  endtask

  task automatic run_prefix(input int n, input logic b14, input string tag);
    for (int i = 0; i < n; i++) access({b14, seq_at(i)}, 1'b1, tag);
  endtask

  task automatic busy_window(input int n_acc);
    @(negedge clk); busy = 1'b1; m_busy = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n_acc; i++)
      access({1'b0, (i % 2) ? 14'h0FC0 : seq_at(i % 5)}, 1'b1, "R9 busy");
    @(negedge clk); busy = 1'b0; m_busy = 1'b0; m_step = 0; m_hiz = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 hiz release", int'(hiz_o), 0);
  endtask

  initial begin
    #(200000 * 10);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C88));
    repeat (3) @(negedge clk);
    check("R10 store reset", int'(store_o), 0);
    check("R10 recall reset", int'(recall_o), 0);
    check("R10 hiz reset", int'(hiz_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_prefix(5, 1'b0, "R3 prefix");
    access(15'h0FC0, 1'b1, "R4 store R1");
    busy_window(3);
    run_prefix(5, 1'b1, "R2 bit14");
    access(15'h4C63, 1'b1, "R4 recall R2");
    busy_window(2);
    run_prefix(3, 1'b0, "R5 part");
    access(15'h1234, 1'b1, "R5 stray");
    run_prefix(5, 1'b0, "R5 after");
    access(15'h0C63, 1'b1, "R5 tail");
    busy_window(0);
    run_prefix(2, 1'b0, "R6 part");
    access({1'b0, seq_at(2)}, 1'b0, "R6 write");
    access({1'b0, seq_at(3)}, 1'b1, "R6 cont");
    access({1'b0, seq_at(4)}, 1'b1, "R6 cont");
    access(15'h0FC0, 1'b1, "R6 tail");
    run_prefix(2, 1'b0, "R7 part");
    access({1'b0, seq_at(1)}, 1'b1, "R7 double");
    access({1'b0, seq_at(2)}, 1'b1, "R7 cont");
    access(15'h0E38, 1'b1, "R7 start");
    access(15'h0E38, 1'b1, "R7 restart");
    for (int i = 1; i < 5; i++) access({1'b0, seq_at(i)}, 1'b1, "R7 seq");
    access(15'h0FC0, 1'b1, "R7 store");
    busy_window(1);
    run_prefix(5, 1'b0, "R9 pre");
    busy_window(0);
    access(15'h0FC0, 1'b1, "R9 reset");

    for (int n = 0; n < 400; n++) begin
      logic [14:0] a;
      logic wn;
      int p = $urandom_range(0, 99);
      if (m_hiz) busy_window($urandom_range(0, 2));
      if (p < 65) a = {1'($urandom), (m_step < 5) ? seq_at(m_step)
                                     : (($urandom % 2) ? 14'h0FC0 : 14'h0C63)};
      else if (p < 85) a = {1'($urandom), seq_at($urandom_range(0, 4))};
      else a = 15'($urandom);
      wn = ($urandom_range(0, 99) < 5) ? 1'b0 : 1'b1;
      access(a, wn, "R1 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule